// File: doc/BRIEF.md
# Serial Offset Register Loader

This block holds the four threshold offsets that the flag logic of a two-direction FIFO pair compares against. There are two offsets for each direction, named Y1, X1, Y2 and X2. Each offset is `$clog2(DEPTH)` bits wide, which is 14 bits at the default depth of 16384. The load method is chosen during reset. While `rst_ni` is low, the block samples `ser_mode_i` on every clock edge and keeps the last value.

- **Serial mode** (`ser_mode_i`=1). The offsets arrive one bit at a time on `ser_d_i`. A bit is taken only on a clock edge where `ser_en_i` is high. The write-side ready output stays low until the whole chain of 4×W bits has arrived. On the edge that takes the last bit, ready goes high and a one-cycle done pulse is issued.
- **Parallel mode** (`ser_mode_i`=0). Each offset is written as a whole word through a select and data port. Ready goes high one clock after reset is released.

All four offsets are presented on the outputs clamped to the legal range, 1 to DEPTH−4.

Top module: `offset_loader`

## Requirements
- R1: While `rst_ni` is low, the bit count is cleared, `ready_o` and `done_o` are 0, and every offset output shows `RST_OFF` (8 by default). `ser_mode_i` is sampled on clock edges during reset. A new reset in the middle of a serial load discards the partial load and restarts the sequence at the first bit.
- R2: In serial mode a bit is taken only on a rising edge where `ser_en_i`=1. Edges with `ser_en_i`=0 change neither the offsets nor the bit count, whatever `ser_d_i` carries.
- R3: The serial chain is 4×W bits long (56 by default). The first bit taken is the MSB of Y1, followed by the rest of Y1, then X1 MSB first, then Y2, then X2. The last bit taken is the LSB of X2.
- R4: In serial mode `ready_o` is 0 until the last chain bit is taken. It reads 1 after the edge that takes that bit and stays 1 until the next reset.
- R5: In serial mode `done_o` is 1 for exactly the one cycle after the edge that takes the last chain bit, and 0 at every other time.
- R6: Once the serial load is complete, further serial bits with `ser_en_i`=1 leave all offsets unchanged and raise no further `done_o`.
- R7: In parallel mode `ready_o` reads 1 after the first rising edge following reset release, and 0 before that edge.
- R8: In parallel mode, `par_we_i`=1 writes `par_data_i` into the offset chosen by `par_sel_i`, taking effect on that edge. The select values are 0=Y1, 1=X1, 2=Y2, 3=X2. Serial inputs are ignored in parallel mode, and parallel writes are ignored in serial mode.
- R9: Each offset output is its stored value clamped to the range 1 to DEPTH−4. A stored 0 reads as 1, and anything above DEPTH−4 reads as DEPTH−4.
- R10: In parallel mode `done_o` never goes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Write-side clock |
| rst_ni | input | 1 | Active-low asynchronous master reset |
| ser_mode_i | input | 1 | Load method, sampled during reset: 1 serial, 0 parallel |
| ser_en_i | input | 1 | Serial bit qualifier |
| ser_d_i | input | 1 | Serial bit |
| par_we_i | input | 1 | Parallel word write strobe |
| par_sel_i | input | 2 | Parallel target: 0 Y1, 1 X1, 2 Y2, 3 X2 |
| par_data_i | input | W | Parallel word |
| ready_o | output | 1 | Write port ready |
| done_o | output | 1 | One-cycle pulse on serial load completion |
| y1_o | output | W | Clamped Y1 offset |
| x1_o | output | W | Clamped X1 offset |
| y2_o | output | W | Clamped Y2 offset |
| x2_o | output | W | Clamped X2 offset |

## Verification
On every cycle the assertions check four properties:
- the bit count never passes the chain length;
- ready never falls outside reset, and stays low while a serial load is incomplete;
- done lasts one cycle, coincides with the rise of ready, and never appears in parallel mode;
- the stored chain does not move on a cycle with neither an accepted bit nor a parallel write.

Only the bench scenarios can show the rest:
- the bit order across the four offsets;
- the clamping of out-of-range words;
- the mode choice made at reset;
- inputs being ignored after completion and across modes.

// File: rtl/offset_pkg.sv
`timescale 1ns/1ps
package offset_pkg;
  localparam int NUM_OFS   = 4;
  localparam int OFS_SEL_W = 2;

  typedef enum logic [OFS_SEL_W-1:0] {
    OFS_Y1 = 2'd0,
    OFS_X1 = 2'd1,
    OFS_Y2 = 2'd2,
    OFS_X2 = 2'd3
  } ofs_sel_e;
endpackage

// File: rtl/offset_bit_counter.sv
`timescale 1ns/1ps
module offset_bit_counter #(
  parameter int TOTAL = 56,
  localparam int CW = $clog2(TOTAL + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ser_mode_i,
  input  logic ser_en_i,
  output logic accept_o,
  output logic full_o,
  output logic ready_o,
  output logic done_o
);
  logic [CW-1:0] cnt_q;
  logic          ready_q, done_q;
  logic          last;

  assign full_o   = (cnt_q == CW'(TOTAL));
  assign accept_o = ser_mode_i & ser_en_i & ~full_o;
  assign last     = accept_o & (cnt_q == CW'(TOTAL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ready_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (accept_o) cnt_q <= cnt_q + 1'b1;
      ready_q <= ready_q | ~ser_mode_i | last;
      done_q  <= last;
    end
  end

  assign ready_o = ready_q;
  assign done_o  = done_q;

  assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(TOTAL));
  assert_done_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  assert_done_par_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ser_mode_i |-> !done_q);
endmodule

// File: rtl/offset_chain.sv
`timescale 1ns/1ps
module offset_chain
  import offset_pkg::*;
#(
  parameter int W       = 14,
  parameter int RST_OFF = 8,
  localparam int TOTAL  = NUM_OFS * W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 shift_i,
  input  logic                 bit_i,
  input  logic                 par_en_i,
  input  logic [OFS_SEL_W-1:0] par_sel_i,
  input  logic [W-1:0]         par_data_i,
  output logic [TOTAL-1:0]     chain_o
);
  logic [TOTAL-1:0] chain_q;

  // Y1 occupies the top slice, so the first bit shifted in ends up as the Y1 MSB.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= {NUM_OFS{W'(RST_OFF)}};
    end else if (shift_i) begin
      chain_q <= {chain_q[TOTAL-2:0], bit_i};
    end else begin
      for (int k = 0; k < NUM_OFS; k++)
        if (par_en_i && par_sel_i == OFS_SEL_W'(k))
          chain_q[(NUM_OFS-1-k)*W +: W] <= par_data_i;
    end
  end

  assign chain_o = chain_q;

  assert_idle_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_i && !par_en_i) |=> $stable(chain_q));
endmodule

// File: rtl/offset_clamp.sv
`timescale 1ns/1ps
module offset_clamp #(
  parameter int W    = 14,
  parameter int MAXV = 16380
) (
  input  logic [W-1:0] val_i,
  output logic [W-1:0] val_o
);
  always_comb begin
    if (val_i == '0)             val_o = W'(1);
    else if (val_i > W'(MAXV))   val_o = W'(MAXV);
    else                         val_o = val_i;
  end
endmodule

// File: rtl/offset_loader.sv
`timescale 1ns/1ps
module offset_loader
  import offset_pkg::*;
#(
  parameter int DEPTH   = 16384,
  parameter int RST_OFF = 8,
  localparam int W      = $clog2(DEPTH),
  localparam int TOTAL  = NUM_OFS * W,
  localparam int MAXV   = DEPTH - 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ser_mode_i,
  input  logic         ser_en_i,
  input  logic         ser_d_i,
  input  logic         par_we_i,
  input  logic [1:0]   par_sel_i,
  input  logic [W-1:0] par_data_i,
  output logic         ready_o,
  output logic         done_o,
  output logic [W-1:0] y1_o,
  output logic [W-1:0] x1_o,
  output logic [W-1:0] y2_o,
  output logic [W-1:0] x2_o
);
  logic             mode_q;
  logic             accept, full;
  logic [TOTAL-1:0] chain;
  logic [W-1:0]     clamped [NUM_OFS];

  // Mode is captured on clock edges while the master reset is held low.
  always_ff @(posedge clk_i) begin
    if (!rst_ni) mode_q <= ser_mode_i;
  end

  offset_bit_counter #(.TOTAL(TOTAL)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ser_mode_i (mode_q),
    .ser_en_i   (ser_en_i),
    .accept_o   (accept),
    .full_o     (full),
    .ready_o    (ready_o),
    .done_o     (done_o)
  );

  offset_chain #(.W(W), .RST_OFF(RST_OFF)) u_chain (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_i    (accept),
    .bit_i      (ser_d_i),
    .par_en_i   (par_we_i & ~mode_q),
    .par_sel_i  (par_sel_i),
    .par_data_i (par_data_i),
    .chain_o    (chain)
  );

  for (genvar k = 0; k < NUM_OFS; k++) begin : g_clamp
    offset_clamp #(.W(W), .MAXV(MAXV)) u_clamp (
      .val_i (chain[(NUM_OFS-1-k)*W +: W]),
      .val_o (clamped[k])
    );
  end

  assign y1_o = clamped[OFS_Y1];
  assign x1_o = clamped[OFS_X1];
  assign y2_o = clamped[OFS_Y2];
  assign x2_o = clamped[OFS_X2];

  assert_ready_wait_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q && !full) |-> !ready_o);
  assert_ready_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);
  assert_done_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $rose(ready_o));
endmodule

// File: tb/tb_offset_loader.sv
`timescale 1ns/1ps
module tb_offset_loader;
  localparam int DEPTH = 16384;
  localparam int W     = $clog2(DEPTH);
  localparam int TOT   = 4 * W;
  localparam int MAXV  = DEPTH - 4;
  localparam int RSTV  = 8;

  logic clk = 0, rst_n = 0;
  logic ser_mode = 1, ser_en = 0, ser_d = 0, par_we = 0;
  logic [1:0] par_sel = 0;
  logic [W-1:0] par_data = 0;
  logic ready, done;
  logic [W-1:0] y1, x1, y2, x2;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  offset_loader #(.DEPTH(DEPTH), .RST_OFF(RSTV)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ser_mode_i(ser_mode), .ser_en_i(ser_en),
    .ser_d_i(ser_d), .par_we_i(par_we), .par_sel_i(par_sel), .par_data_i(par_data),
    .ready_o(ready), .done_o(done), .y1_o(y1), .x1_o(x1), .y2_o(y2), .x2_o(x2)
  );

  function automatic int clampv(int v);
    if (v == 0) return 1;
    if (v > MAXV) return MAXV;
    return v;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_offs(string req, int e0, int e1, int e2, int e3);
    chk(req, y1, clampv(e0));
    chk(req, x1, clampv(e1));
    chk(req, y2, clampv(e2));
    chk(req, x2, clampv(e3));
  endtask

  task automatic do_reset(logic mode);
    @(negedge clk);
    rst_n = 0; ser_mode = mode; ser_en = 0; par_we = 0;
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", ready, 0);
    chk("R1 done in reset", done, 0);
    chk_offs("R1 reset values", RSTV, RSTV, RSTV, RSTV);
    rst_n = 1;
  endtask

  task automatic ser_load(int v0, int v1, int v2, int v3, int gap_pct);
    logic [TOT-1:0] pk;
    pk = {W'(v0), W'(v1), W'(v2), W'(v3)};
    for (int i = 0; i < TOT; i++) begin
      while ($urandom_range(0, 99) < gap_pct) begin
        ser_en = 0; ser_d = 1'($urandom);
        @(negedge clk);
        chk("R4 ready low in gap", ready, 0);
        chk("R2 done low in gap", done, 0);
      end
      ser_en = 1; ser_d = pk[TOT-1-i];
      @(negedge clk);
      if (i < TOT - 1) begin
        chk("R4 ready low mid-load", ready, 0);
        chk("R5 done low mid-load", done, 0);
      end else begin
        chk("R4 ready on last bit", ready, 1);
        chk("R5 done on last bit", done, 1);
      end
    end
    ser_en = 0;
    @(negedge clk);
    chk("R5 done single cycle", done, 0);
    chk("R4 ready held", ready, 1);
    chk_offs("R3 serial order", v0, v1, v2, v3);
  endtask

  task automatic par_write(int sel, int val);
    par_we = 1; par_sel = 2'(sel); par_data = W'(val);
    @(negedge clk);
    par_we = 0;
  endtask

  initial begin
    #(5.0 * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int v[4];
    void'($urandom(32'd1234));

    // R1 reset state, serial mode
    do_reset(1'b1);
    chk("R4 ready after release", ready, 0);

    // R3 R4 R5 directed load, no gaps
    ser_load(16'h2AB, 16'h1, 16'h3FFC, 16'h155, 0);

    // R6 extra bits after completion; R8 parallel write ignored in serial mode
    for (int i = 0; i < 20; i++) begin
      ser_en = 1; ser_d = 1'($urandom);
      @(negedge clk);
      chk("R6 no done after load", done, 0);
    end
    ser_en = 0;
    chk_offs("R6 offsets frozen", 16'h2AB, 16'h1, 16'h3FFC, 16'h155);
    par_write(1, 77);
    chk_offs("R8 parallel ignored in serial", 16'h2AB, 16'h1, 16'h3FFC, 16'h155);
    chk("R4 ready stays", ready, 1);

    // R1 reset mid-load restarts sequence
    do_reset(1'b1);
    for (int i = 0; i < 30; i++) begin
      ser_en = 1; ser_d = 1'($urandom);
      @(negedge clk);
    end
    ser_en = 0;
    do_reset(1'b1);
    chk("R1 ready after restart", ready, 0);
    for (int k = 0; k < 4; k++) v[k] = $urandom_range(1, MAXV);
    ser_load(v[0], v[1], v[2], v[3], 30);  // R2 gaps

    // random loads with gaps
    for (int n = 0; n < 3; n++) begin
      do_reset(1'b1);
      for (int k = 0; k < 4; k++) v[k] = $urandom_range(1, MAXV);
      ser_load(v[0], v[1], v[2], v[3], 20);
    end

    // R9 clamp through serial path
    do_reset(1'b1);
    ser_load(0, DEPTH - 1, MAXV, MAXV + 1, 10);
    chk("R9 zero to one", y1, 1);
    chk("R9 top clamps", x2, MAXV);

    // R7 parallel mode
    do_reset(1'b0);
    chk("R7 ready before edge", ready, 0);
    @(negedge clk);
    chk("R7 ready after edge", ready, 1);
    for (int i = 0; i < 2 * TOT; i++) begin
      ser_en = 1; ser_d = 1'($urandom);
      @(negedge clk);
      chk("R10 no done in parallel", done, 0);
    end
    ser_en = 0;
    chk_offs("R8 serial ignored in parallel", RSTV, RSTV, RSTV, RSTV);

    // R8 parallel writes
    for (int n = 0; n < 4; n++) begin
      for (int k = 0; k < 4; k++) begin
        v[k] = $urandom_range(1, MAXV);
        par_write(k, v[k]);
      end
      chk_offs("R8 parallel write", v[0], v[1], v[2], v[3]);
    end
    par_write(2, 0);
    chk("R9 parallel zero", y2, 1);
    par_write(0, DEPTH - 1);
    chk("R9 parallel max", y1, MAXV);
    chk("R8 other untouched", x1, v[1]);
    chk("R10 done still low", done, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule